// File: doc/BRIEF.md
# Dual-Word Phase Accumulator with Selectable Offsets

This block is the numerically controlled oscillator core of a waveform synthesizer. It keeps two 32-bit tuning words and four 12-bit phase offsets. On every clock it adds the chosen tuning word to a 32-bit accumulator. It then adds the chosen offset to the top 12 bits of the accumulator and emits that sum as the output phase. The output frequency is the clock rate times the tuning word divided by 2^32. One offset step is 2π/4096. Amplitude lookup and conversion happen downstream and are not part of the block.

Each tuning word is stored as a low half and a high half, and each half is written on its own. The choice of tuning word and offset comes either from select pins or from select bits held in a register, as a source bit decides. An optional two-stage synchronizer can be placed in front of both the select pins and the write path. It adds exactly two cycles to every latency. A hold input keeps the accumulator at zero without touching the stored words.

Writes enter through a valid/ready port. Ready is tied high, so the block never applies back-pressure, and every clock edge at which valid is high commits exactly one write. The select pins and the hold input are plain level inputs.

Top module: `nco_phase_core`

## Requirements
- R1: Each clock the accumulator advances by the selected 32-bit tuning word, modulo 2^32. The output is the top 12 bits of (accumulator + offset·2^20), modulo 2^32.
- R2: Ready is always 1, and each edge with valid high commits one write. Address 0 is the low half and address 1 the high half of tuning word 0. Address 2 is the low half and address 3 the high half of tuning word 1. Addresses 4 to 7 are phase offsets 0 to 3 and take data bits 11:0; data bits 15:12 are ignored.
- R3: Writing one half of a tuning word leaves the other half unchanged.
- R4: Address 8 holds the select bits: bit 0 picks the tuning word and bits 2:1 pick the offset. Address 9 holds the control bits: bit 0 enables the synchronizer and bit 1 sets the source. With the source at 1, the select bits are used and the select pins have no effect. With the source at 0, the pins are used.
- R5: While hold is 1 the accumulator stays at 0, so the output equals the selected offset. Tuning words and offsets keep their contents through any hold.
- R6: Take r as the first edge at which hold is seen low. The output after edge r+5 still equals the offset. After edge r+6 it equals the top 12 bits of (W + offset·2^20), where W is the tuning word. From then on it advances by W each cycle.
- R7: A select pin change first sampled at edge m shows on the output after edge m+6 with the synchronizer off. With it on, it shows after edge m+8, and the output after the edge just before still shows the old selection.
- R8: Take w as the write edge. A write to the selected offset shows on the output after edge w+6, or w+8 with the synchronizer on. A write to the selected tuning word changes the output step from edge w+7 onward, or w+9 with the synchronizer on.
- R9: Clear (rst_n low) zeroes all stored words, the select bits, the accumulator and the output. It turns the synchronizer off and returns control to the pins.
- R10: Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| wr_valid | input | 1 | Write request; one commit per edge while high |
| wr_ready | output | 1 | Always 1; the write port never stalls |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| fsel_pin | input | 1 | Tuning-word select pin |
| psel_pin | input | 2 | Offset select pins |
| acc_hold | input | 1 | Holds the accumulator at zero while 1 |
| phase_out | output | 12 | Output phase, top 12 bits |

## Verification
The accumulator is run from hold release against an arithmetic model under several patterns, and each pattern separates a different fault. Top-aligned tuning words with a nonzero offset check the adder and the offset alignment. Words carrying only a low-half fraction check the carry from the low half into the output bits and show whether the two halves are stored apart. Latency is measured edge by edge, one cycle before and at the expected edge, for pin changes, offset writes and tuning-word writes, with the synchronizer both off and on. Source switching is checked by sweeping every pin combination while the select bits are in control. Unused addresses are checked by writing each one and confirming that output, control and tuning words are unchanged.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int CTRL_SYNC_BIT = 0;
  localparam int CTRL_SRC_BIT  = 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/nco_regbank.sv
`timescale 1ns/1ps
module nco_regbank
  import nco_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int PH_W        = 12,
  parameter int N_FREQ      = 2,
  parameter int N_PHASE     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FI_W = $clog2(N_FREQ),
  localparam int PI_W = $clog2(N_PHASE)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_valid,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [N_FREQ-1:0][2*HALF_W-1:0]    freq_word,
  output logic [N_PHASE-1:0][PH_W-1:0]       phase_word,
  output logic [FI_W-1:0]                    bit_f,
  output logic [PI_W-1:0]                    bit_p,
  output logic                               sync_en,
  output logic                               src_bits
);
  localparam logic [ADDR_W-1:0] PH_BASE   = ADDR_W'(2*N_FREQ);
  localparam logic [ADDR_W-1:0] SEL_ADDR  = ADDR_W'(2*N_FREQ + N_PHASE);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2*N_FREQ + N_PHASE + 1);

  wr_cmd_t                          cmd_in, cmd_use;
  logic                             apply;
  logic [SYNC_STAGES-1:0]           dly_v;
  wr_cmd_t [SYNC_STAGES-1:0]        dly_c;
  logic [N_FREQ-1:0][HALF_W-1:0]    lo_q, hi_q;
  logic [N_PHASE-1:0][PH_W-1:0]     ph_q;
  logic [FI_W-1:0]                  self_q;
  logic [PI_W-1:0]                  selp_q;
  logic                             sync_q, src_q;
  logic [FI_W-1:0]                  f_idx;
  logic [PI_W-1:0]                  ph_idx;

  assign cmd_in = {wr_addr, wr_data};

  // optional delay of the write path, same depth as the pin synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_v <= '0;
    end else begin
      dly_v[0] <= wr_valid;
      for (int i = 1; i < SYNC_STAGES; i++) dly_v[i] <= dly_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dly_c[0] <= cmd_in;
    for (int i = 1; i < SYNC_STAGES; i++) dly_c[i] <= dly_c[i-1];
  end

  assign apply   = sync_q ? dly_v[SYNC_STAGES-1] : wr_valid;
  assign cmd_use = sync_q ? dly_c[SYNC_STAGES-1] : cmd_in;
  assign f_idx   = cmd_use.addr[FI_W:1];
  assign ph_idx  = PI_W'(cmd_use.addr - PH_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ph_q   <= '0;
      self_q <= '0;
      selp_q <= '0;
      sync_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (apply) begin
      if (cmd_use.addr < PH_BASE) begin
        if (cmd_use.addr[0]) hi_q[f_idx] <= cmd_use.data;
        else                 lo_q[f_idx] <= cmd_use.data;
      end else if (cmd_use.addr < SEL_ADDR) begin
        ph_q[ph_idx] <= cmd_use.data[PH_W-1:0];
      end else if (cmd_use.addr == SEL_ADDR) begin
        self_q <= cmd_use.data[FI_W-1:0];
        selp_q <= cmd_use.data[FI_W +: PI_W];
      end else if (cmd_use.addr == CTRL_ADDR) begin
        sync_q <= cmd_use.data[CTRL_SYNC_BIT];
        src_q  <= cmd_use.data[CTRL_SRC_BIT];
      end
    end
  end

  for (genvar g = 0; g < N_FREQ; g++) begin : g_word
    assign freq_word[g] = {hi_q[g], lo_q[g]};
  end

  assign phase_word = ph_q;
  assign bit_f      = self_q;
  assign bit_p      = selp_q;
  assign sync_en    = sync_q;
  assign src_bits   = src_q;

  // R3
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd_use.addr == ADDR_W'(1)) |=> $stable(lo_q[0]));

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd_use.addr == ADDR_W'(0)) |=> $stable(hi_q[0]));

  // R10
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd_use.addr > CTRL_ADDR) |=>
      $stable({lo_q, hi_q, ph_q, self_q, selp_q, sync_q, src_q}));
endmodule

// File: rtl/nco_select.sv
`timescale 1ns/1ps
module nco_select #(
  parameter int FI_W        = 1,
  parameter int PI_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FI_W-1:0] pin_f,
  input  logic [PI_W-1:0] pin_p,
  input  logic [FI_W-1:0] bit_f,
  input  logic [PI_W-1:0] bit_p,
  input  logic            sync_en,
  input  logic            src,
  output logic [FI_W-1:0] eff_f,
  output logic [PI_W-1:0] psel_q
);
  localparam int SW = FI_W + PI_W;

  logic [SYNC_STAGES-1:0][SW-1:0] sync_q;
  logic [SW-1:0]                  pin_raw, pin_use, eff;

  assign pin_raw = {pin_f, pin_p};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pin_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_use = sync_en ? sync_q[SYNC_STAGES-1] : pin_raw;
  assign eff     = src ? {bit_f, bit_p} : pin_use;
  assign eff_f   = eff[SW-1 -: FI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psel_q <= '0;
    else        psel_q <= eff[PI_W-1:0];
  end

  // R4
  src_ignores_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src |=> psel_q == $past(bit_p));
endmodule

// File: rtl/nco_accum.sv
`timescale 1ns/1ps
module nco_accum #(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 12,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4,
  parameter int OUT_LAT = 6,
  localparam int FI_W = $clog2(N_FREQ),
  localparam int PI_W = $clog2(N_PHASE)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hold,
  input  logic [N_FREQ-1:0][ACC_W-1:0]   freq_word,
  input  logic [N_PHASE-1:0][PH_W-1:0]   phase_word,
  input  logic [FI_W-1:0]                eff_f,
  input  logic [PI_W-1:0]                psel_q,
  output logic [PH_W-1:0]                phase_out
);
  logic [ACC_W-1:0]              acc_q;
  logic [PH_W-1:0]               ph_now;
  logic [OUT_LAT-1:0][PH_W-1:0]  pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (hold) acc_q <= '0;
    else           acc_q <= acc_q + freq_word[eff_f];
  end

  // offset has no bits below the output field, so no carry enters from below
  assign ph_now = acc_q[ACC_W-1 -: PH_W] + phase_word[psel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= ph_now;
      for (int i = 1; i < OUT_LAT; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign phase_out = pipe_q[OUT_LAT-1];

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> acc_q == '0);
endmodule

// File: rtl/nco_phase_core.sv
`timescale 1ns/1ps
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int PH_W        = 12,
  parameter int N_FREQ      = 2,
  parameter int N_PHASE     = 4,
  parameter int OUT_LAT     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int FI_W = $clog2(N_FREQ),
  localparam int PI_W = $clog2(N_PHASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FI_W-1:0]   fsel_pin,
  input  logic [PI_W-1:0]   psel_pin,
  input  logic              acc_hold,
  output logic [PH_W-1:0]   phase_out
);
  localparam int HALF_W = ACC_W / 2;

  logic [N_FREQ-1:0][ACC_W-1:0]  freq_word;
  logic [N_PHASE-1:0][PH_W-1:0]  phase_word;
  logic [FI_W-1:0]               bit_f, eff_f;
  logic [PI_W-1:0]               bit_p, psel_q;
  logic                          sync_en, src_bits;

  assign wr_ready = 1'b1;

  nco_regbank #(
    .HALF_W(HALF_W), .PH_W(PH_W), .N_FREQ(N_FREQ),
    .N_PHASE(N_PHASE), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_word(freq_word), .phase_word(phase_word),
    .bit_f(bit_f), .bit_p(bit_p),
    .sync_en(sync_en), .src_bits(src_bits)
  );

  nco_select #(
    .FI_W(FI_W), .PI_W(PI_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk(clk), .rst_n(rst_n),
    .pin_f(fsel_pin), .pin_p(psel_pin),
    .bit_f(bit_f), .bit_p(bit_p),
    .sync_en(sync_en), .src(src_bits),
    .eff_f(eff_f), .psel_q(psel_q)
  );

  nco_accum #(
    .ACC_W(ACC_W), .PH_W(PH_W), .N_FREQ(N_FREQ),
    .N_PHASE(N_PHASE), .OUT_LAT(OUT_LAT)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .hold(acc_hold),
    .freq_word(freq_word), .phase_word(phase_word),
    .eff_f(eff_f), .psel_q(psel_q),
    .phase_out(phase_out)
  );
endmodule

// File: tb/nco_phase_core_test.sv
`timescale 1ns/1ps
module nco_phase_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fsel_pin = 1'b0;
  logic [1:0]  psel_pin = '0;
  logic        acc_hold = 1'b1;
  logic [11:0] phase_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  nco_phase_core uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fsel_pin(fsel_pin),
    .psel_pin(psel_pin), .acc_hold(acc_hold), .phase_out(phase_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ph_exp(input logic [31:0] acc, input logic [11:0] off);
    logic [31:0] s;
    s = acc + {off, 20'h0};
    return s[31:20];
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // precondition: hold high and settled
  task automatic run_seq(input logic [31:0] f, input logic [11:0] off, input int n, input string req);
    acc_hold = 1'b0;
    wait_n(6);
    chk("R6 output one cycle before release shows", phase_out, {20'h0, off});
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      chk(req, phase_out, {20'h0, ph_exp(f * 32'(j + 1), off)});
      @(negedge clk);
    end
    acc_hold = 1'b1;
    wait_n(8);
  endtask

  task automatic pin_lat(input logic [1:0] np, input logic [11:0] old_v, input logic [11:0] new_v,
                         input int lat, input string req);
    psel_pin = np;
    wait_n(lat);
    chk({req, " before"}, phase_out, {20'h0, old_v});
    wait_n(1);
    chk({req, " at"}, phase_out, {20'h0, new_v});
  endtask

  task automatic ph_wr_lat(input logic [3:0] a, input logic [11:0] old_v, input logic [11:0] new_v,
                           input int lat, input string req);
    wr_valid = 1'b1; wr_addr = a; wr_data = {4'h0, new_v};
    @(negedge clk);
    wr_valid = 1'b0;
    wait_n(lat - 1);
    chk({req, " before"}, phase_out, {20'h0, old_v});
    wait_n(1);
    chk({req, " at"}, phase_out, {20'h0, new_v});
  endtask

  // precondition: accumulator running with a top-aligned word
  task automatic step_wr_lat(input logic [15:0] new_hi, input logic [11:0] old_s,
                             input logic [11:0] new_s, input int lat, input string req);
    logic [11:0] prev;
    logic [11:0] d;
    prev = phase_out;
    wr_valid = 1'b1; wr_addr = 4'd1; wr_data = new_hi;
    for (int n = 1; n <= lat + 2; n++) begin
      @(negedge clk);
      if (n == 1) wr_valid = 1'b0;
      d = phase_out - prev;
      prev = phase_out;
      if (n == lat)     chk({req, " step before"}, d, old_s);
      if (n == lat + 1) chk({req, " step at"}, d, new_s);
      if (n == lat + 2) chk({req, " step after"}, d, new_s);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] offs [4];
    offs[0] = 12'h123; offs[1] = 12'h9A5; offs[2] = 12'hFFF; offs[3] = 12'h001;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 reset output", phase_out, 0);
    chk("R2 ready high", wr_ready, 1);

    // R2: phase offsets, upper data bits garbage
    for (int i = 0; i < 4; i++) wr(4'(4 + i), {4'hA, offs[i]});
    // R5: under hold output equals each offset
    for (int p = 0; p < 4; p++) begin
      psel_pin = 2'(p);
      wait_n(8);
      chk("R5 R2 held output equals offset", phase_out, {20'h0, offs[p]});
    end

    // R7 synchronizer off
    pin_lat(2'd1, offs[3], offs[1], 6, "R7 pin latency sync off");

    // R1 both tuning words
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0030);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h0105);
    wait_n(8);
    fsel_pin = 1'b0; wait_n(8);
    run_seq(32'h0030_0000, offs[1], 40, "R1 word0 accumulation");
    fsel_pin = 1'b1; wait_n(8);
    run_seq(32'h0105_0000, offs[1], 40, "R1 word1 accumulation");

    // R3 independent halves; R5 words retained across holds
    fsel_pin = 1'b0;
    wr(4'd0, 16'h8000); wait_n(8);
    run_seq(32'h0030_8000, offs[1], 40, "R3 low half added");
    wr(4'd1, 16'h0000); wait_n(8);
    run_seq(32'h0000_8000, offs[1], 70, "R3 high half cleared low kept");

    // R8 synchronizer off
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0030);
    psel_pin = 2'd0; wait_n(8);
    chk("R8 offset before write", phase_out, {20'h0, offs[0]});
    ph_wr_lat(4'd4, offs[0], 12'h456, 6, "R8 offset write sync off");
    offs[0] = 12'h456;
    acc_hold = 1'b0; wait_n(12);
    step_wr_lat(16'h0070, 12'd3, 12'd7, 7, "R8 word write sync off");
    acc_hold = 1'b1; wait_n(8);

    // synchronizer on
    wr(4'd9, 16'h0001); wait_n(8);
    pin_lat(2'd2, offs[0], offs[2], 8, "R7 pin latency sync on");
    psel_pin = 2'd0; wait_n(12);
    ph_wr_lat(4'd4, offs[0], 12'h789, 8, "R8 offset write sync on");
    offs[0] = 12'h789;
    acc_hold = 1'b0; wait_n(12);
    step_wr_lat(16'h0020, 12'd7, 12'd2, 9, "R8 word write sync on");
    acc_hold = 1'b1; wait_n(8);

    // R4 select bits in control: word 1, offset 2
    wr(4'd8, 16'h0005);
    wr(4'd9, 16'h0003);
    wait_n(12);
    chk("R4 bits select offset", phase_out, {20'h0, offs[2]});
    for (int c = 0; c < 8; c++) begin
      fsel_pin = c[2];
      psel_pin = c[1:0];
      wait_n(10);
      chk("R4 pins ignored", phase_out, {20'h0, offs[2]});
    end
    fsel_pin = 1'b0; psel_pin = 2'd0;
    run_seq(32'h0105_0000, offs[2], 30, "R4 bits select word");

    // R10 unused addresses
    for (int a = 10; a < 16; a++) wr(4'(a), 16'hFFFF);
    wait_n(12);
    chk("R10 output unchanged", phase_out, {20'h0, offs[2]});
    psel_pin = 2'd1; wait_n(12);
    chk("R10 source unchanged", phase_out, {20'h0, offs[2]});
    run_seq(32'h0105_0000, offs[2], 20, "R10 words unchanged");

    // R9 clear
    rst_n = 1'b0;
    #1;
    chk("R9 output cleared", phase_out, 0);
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 output after clear", phase_out, 0);
    psel_pin = 2'd1;
    wr(4'd5, 16'h0777);
    wait_n(8);
    chk("R9 pins back in control", phase_out, 32'h777);
    pin_lat(2'd0, 12'h777, 12'h000, 6, "R9 synchronizer off and offsets cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule